// File: doc/BRIEF.md
# Display Bridge Power and Reset Sequencer

This block drives the supply enable, powerdown and reset pins of a display bridge. A resume request, or any activity while the bridge is off, starts a fixed power-up order. Supplies come on first. Powerdown is then released while reset is held. Reset is then pulsed a second time. A settle period follows before the ready flag rises. A suspend request, or an idle period with no activity, runs the opposite order: reset, then powerdown, then supplies.

Once the bridge is ready, the block watches the hot-plug-detect level. It samples this level at fixed intervals until it is seen high or a wait limit runs out. The first high level after each reset sequence adds one extra delay before the HPD-ready flag rises. Later waits, which software can restart while running, skip that delay.

Every duration is counted in pulses of a one-cycle millisecond tick input, and each one is a parameter.

Top module: `bridge_pwr_seq`

## Requirements
- R11: After reset, supply_en_o is 0, pwrdn_o and reset_o are 1, and ready_o, hpd_ready_o and hpd_tout_o are 0.
- R1: A resume raises supply_en_o first. One clock later pwrdn_o falls while reset_o stays 1. reset_o falls after RST_HOLD_T further tick pulses.
- R2: After the first release, reset_o stays 0 for RST_GAP_T ticks, then 1 for RST_HOLD2_T ticks, then falls again.
- R3: ready_o rises SETTLE_T ticks after the second reset release. While ready_o is 1, supply_en_o is 1 and pwrdn_o and reset_o are 0.
- R4: Each reset sequence arms a first-HPD delay. The first time HPD is seen high after that, hpd_ready_o rises FIRST_HPD_T ticks later and the delay is disarmed.
- R5: A pulse on hpd_wait_i while ready clears both HPD flags and starts a new wait. With the delay disarmed, hpd_ready_o rises on the same sample that sees HPD high.
- R6: A wait samples hpd_i once when it starts and again every POLL_T ticks. If HPD is still low at the sample that falls HPD_LIMIT_T ticks after the start, hpd_tout_o rises. The two HPD flags are never 1 together.
- R7: A suspend from the ready state sets reset_o to 1 and clears ready_o and both HPD flags on one clock edge. pwrdn_o rises on the next clock and supply_en_o falls on the clock after that.
- R8: After IDLE_T ticks in the ready state with no activity_i pulse, the suspend order of R7 starts by itself. Each activity_i pulse restarts this count.
- R9: While off, either resume_req_i or activity_i starts the full resume of R1. While ready, resume_req_i has no effect.
- R10: A suspend request during an unfinished resume abandons it and runs the suspend order from the current pin state. During the supplies-only step, this means only the supplies are turned off. ready_o does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle millisecond tick |
| resume_req_i | input | 1 | Request power-up |
| suspend_req_i | input | 1 | Request power-down |
| activity_i | input | 1 | Activity pulse: wakes when off, restarts the idle count when ready |
| hpd_wait_i | input | 1 | Restart the HPD wait while ready |
| hpd_i | input | 1 | Hot-plug-detect level |
| supply_en_o | output | 1 | Supply enable |
| pwrdn_o | output | 1 | Powerdown, active high |
| reset_o | output | 1 | Bridge reset, active high |
| ready_o | output | 1 | Resume sequence complete |
| hpd_ready_o | output | 1 | HPD seen high, including any first-HPD delay |
| hpd_tout_o | output | 1 | HPD wait limit expired |

## Verification
A request registers on the next clock edge. Each timed step changes the pins on the edge that samples its last counted tick, and a tick on the edge that enters a step is not counted. Every later suspend step lands exactly one clock after the one before it. The bench logs each pin change at the falling clock edge, together with the number of ticks it has driven so far. A scoreboard compares each change against an expected item carrying a tick distance measured from the previous change or from the last activity pulse. The distance is left unchecked only for request-driven steps, whose tick alignment is free.

// File: rtl/bps_pkg.sv
package bps_pkg;

  typedef enum logic [3:0] {
    S_OFF, S_PWR_ON, S_RST1, S_GAP, S_RST2, S_SETTLE, S_RUN, S_SUSP_RST, S_SUSP_PD
  } seq_state_e;

  typedef enum logic [2:0] {
    H_IDLE, H_POLL, H_EXTRA, H_DONE, H_TOUT
  } hpd_state_e;

  typedef struct packed {
    logic sup;
    logic pd;
    logic rst;
    logic rdy;
  } pin_set_t;

  function automatic pin_set_t pins_of(seq_state_e s);
    pin_set_t p;
    p = '{sup: 1'b1, pd: 1'b0, rst: 1'b0, rdy: 1'b0};
    case (s)
      S_OFF:      begin p.sup = 1'b0; p.pd = 1'b1; p.rst = 1'b1; end
      S_PWR_ON:   begin p.pd = 1'b1; p.rst = 1'b1; end
      S_RST1:     p.rst = 1'b1;
      S_RST2:     p.rst = 1'b1;
      S_RUN:      p.rdy = 1'b1;
      S_SUSP_RST: p.rst = 1'b1;
      S_SUSP_PD:  begin p.pd = 1'b1; p.rst = 1'b1; end
      default:    ;
    endcase
    return p;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bps_tick_timer.sv
module bps_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || done_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i); // R8

endmodule

// File: rtl/bps_hpd_gate.sv
module bps_hpd_gate
  import bps_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned POLL_T      = 20,
  parameter int unsigned HPD_LIMIT_T = 200,
  parameter int unsigned FIRST_HPD_T = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic start_i,
  input  logic arm_i,
  input  logic hpd_i,
  output logic hpd_ready_o,
  output logic hpd_tout_o
);
  localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_T - 1);
  localparam logic [CNT_W:0]   LIMIT     = (CNT_W+1)'(HPD_LIMIT_T);

  hpd_state_e       hst_q, hst_d;
  logic [CNT_W-1:0] elapsed_q, sub_q;
  logic             armed_q;
  logic             poll_hit, extra_done, extra_clr;
  hpd_state_e       hit_state;

  assign poll_hit  = (hst_q == H_POLL) && tick_i && (sub_q == POLL_LAST);
  assign hit_state = armed_q ? H_EXTRA : H_DONE;
  assign extra_clr = (hst_q != H_EXTRA) || start_i;

  bps_tick_timer #(.CNT_W(CNT_W)) u_extra (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (extra_clr),
    .tick_i  (tick_i),
    .limit_i (CNT_W'(FIRST_HPD_T)),
    .done_o  (extra_done)
  );

  always_comb begin
    hst_d = hst_q;
    if (!run_i)       hst_d = H_IDLE;
    else if (start_i) hst_d = hpd_i ? hit_state : H_POLL;
    else begin
      case (hst_q)
        H_POLL: if (poll_hit) begin
          if (hpd_i)                                    hst_d = hit_state;
          else if (({1'b0, elapsed_q} + 1'b1) >= LIMIT) hst_d = H_TOUT;
        end
        H_EXTRA: if (extra_done) hst_d = H_DONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hst_q     <= H_IDLE;
      elapsed_q <= '0;
      sub_q     <= '0;
      armed_q   <= 1'b0;
    end else begin
      hst_q <= hst_d;
      if (start_i) begin
        elapsed_q <= '0;
        sub_q     <= '0;
      end else if (hst_q == H_POLL && tick_i) begin
        elapsed_q <= elapsed_q + 1'b1;
        sub_q     <= (sub_q == POLL_LAST) ? '0 : sub_q + 1'b1;
      end
      if (arm_i)                                       armed_q <= 1'b1;
      else if (hst_q == H_EXTRA && hst_d == H_DONE)    armed_q <= 1'b0;
    end
  end

  assign hpd_ready_o = (hst_q == H_DONE);
  assign hpd_tout_o  = (hst_q == H_TOUT);

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hpd_ready_o && hpd_tout_o)); // R6
  AST_DISARM_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_q) |-> hpd_ready_o); // R4

endmodule

// File: rtl/bridge_pwr_seq.sv
module bridge_pwr_seq
  import bps_pkg::*;
#(
  parameter int unsigned RST_HOLD_T  = 2,
  parameter int unsigned RST_GAP_T   = 50,
  parameter int unsigned RST_HOLD2_T = 50,
  parameter int unsigned SETTLE_T    = 200,
  parameter int unsigned POLL_T      = 20,
  parameter int unsigned HPD_LIMIT_T = 200,
  parameter int unsigned FIRST_HPD_T = 50,
  parameter int unsigned IDLE_T      = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic resume_req_i,
  input  logic suspend_req_i,
  input  logic activity_i,
  input  logic hpd_wait_i,
  input  logic hpd_i,
  output logic supply_en_o,
  output logic pwrdn_o,
  output logic reset_o,
  output logic ready_o,
  output logic hpd_ready_o,
  output logic hpd_tout_o
);
  localparam int unsigned MAX_T = max2(max2(max2(RST_HOLD_T, RST_GAP_T), max2(RST_HOLD2_T, SETTLE_T)),
                                       max2(max2(POLL_T, HPD_LIMIT_T), max2(FIRST_HPD_T, IDLE_T)));
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] step_limit;
  logic             step_done, step_clr;
  logic             idle_done, idle_clr;
  logic             run_next, hpd_start, arm_seq;
  pin_set_t         pins;

  always_comb begin
    case (state_q)
      S_RST1:   step_limit = CNT_W'(RST_HOLD_T);
      S_GAP:    step_limit = CNT_W'(RST_GAP_T);
      S_RST2:   step_limit = CNT_W'(RST_HOLD2_T);
      S_SETTLE: step_limit = CNT_W'(SETTLE_T);
      default:  step_limit = CNT_W'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_OFF:      if (resume_req_i || activity_i) state_d = S_PWR_ON;
      S_PWR_ON:   state_d = suspend_req_i ? S_SUSP_PD : S_RST1;
      S_RST1:     if (suspend_req_i) state_d = S_SUSP_RST; else if (step_done) state_d = S_GAP;
      S_GAP:      if (suspend_req_i) state_d = S_SUSP_RST; else if (step_done) state_d = S_RST2;
      S_RST2:     if (suspend_req_i) state_d = S_SUSP_RST; else if (step_done) state_d = S_SETTLE;
      S_SETTLE:   if (suspend_req_i) state_d = S_SUSP_RST; else if (step_done) state_d = S_RUN;
      S_RUN:      if (suspend_req_i || idle_done) state_d = S_SUSP_RST;
      S_SUSP_RST: state_d = S_SUSP_PD;
      S_SUSP_PD:  state_d = S_OFF;
      default:    state_d = S_OFF;
    endcase
  end

  assign step_clr  = (state_d != state_q);
  assign idle_clr  = activity_i || (state_q != S_RUN);
  assign run_next  = (state_d == S_RUN);
  assign hpd_start = run_next && ((state_q != S_RUN) || hpd_wait_i);
  assign arm_seq   = (state_d == S_RST1) && (state_q != S_RST1);

  bps_tick_timer #(.CNT_W(CNT_W)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (step_clr),
    .tick_i  (tick_i),
    .limit_i (step_limit),
    .done_o  (step_done)
  );

  bps_tick_timer #(.CNT_W(CNT_W)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (idle_clr),
    .tick_i  (tick_i),
    .limit_i (CNT_W'(IDLE_T)),
    .done_o  (idle_done)
  );

  bps_hpd_gate #(
    .CNT_W       (CNT_W),
    .POLL_T      (POLL_T),
    .HPD_LIMIT_T (HPD_LIMIT_T),
    .FIRST_HPD_T (FIRST_HPD_T)
  ) u_hpd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .run_i       (run_next),
    .start_i     (hpd_start),
    .arm_i       (arm_seq),
    .hpd_i       (hpd_i),
    .hpd_ready_o (hpd_ready_o),
    .hpd_tout_o  (hpd_tout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_OFF;
    else         state_q <= state_d;
  end

  assign pins        = pins_of(state_q);
  assign supply_en_o = pins.sup;
  assign pwrdn_o     = pins.pd;
  assign reset_o     = pins.rst;
  assign ready_o     = pins.rdy;

  AST_PD_NEEDS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_o |-> supply_en_o); // R1
  AST_RESUME_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supply_en_o) |-> pwrdn_o && reset_o); // R1
  AST_READY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> supply_en_o && !pwrdn_o && !reset_o); // R3
  AST_PD_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwrdn_o) |-> $past(reset_o)); // R7
  AST_SUP_AFTER_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(supply_en_o) |-> $past(pwrdn_o) && $past(reset_o)); // R7

endmodule

// File: tb/sim_bridge_pwr_seq.sv
`timescale 1ns/100ps
module sim_bridge_pwr_seq;
  localparam int T_R1 = 2, T_GAP = 6, T_R2 = 6, T_SET = 10;
  localparam int T_POLL = 2, T_LIM = 10, T_EXT = 4, T_IDLE = 120;
  localparam int SUP = 0, PWD = 1, RST = 2, RDY = 3, HPD = 4, TMO = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic resume_req = 1'b0, suspend_req = 1'b0, activity = 1'b0, hpd_wait = 1'b0, hpd = 1'b0;
  logic supply_en, pwrdn, reset_pin, ready, hpd_ready, hpd_tout;

  typedef struct { int code; int delta; bit anc; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, tick_cnt = 0, last_stamp = 0, anchor = 0, div = 0;
  bit mon_en = 1'b0;
  string cur_req = "R11";
  logic [5:0] prev_pins;

  always #2.5 clk = ~clk;

  bridge_pwr_seq #(
    .RST_HOLD_T(T_R1), .RST_GAP_T(T_GAP), .RST_HOLD2_T(T_R2), .SETTLE_T(T_SET),
    .POLL_T(T_POLL), .HPD_LIMIT_T(T_LIM), .FIRST_HPD_T(T_EXT), .IDLE_T(T_IDLE)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .resume_req_i(resume_req),
    .suspend_req_i(suspend_req), .activity_i(activity), .hpd_wait_i(hpd_wait), .hpd_i(hpd),
    .supply_en_o(supply_en), .pwrdn_o(pwrdn), .reset_o(reset_pin), .ready_o(ready),
    .hpd_ready_o(hpd_ready), .hpd_tout_o(hpd_tout)
  );

  initial forever begin
    @(negedge clk);
    div  = (div + 1) % 4;
    tick = (div == 0) && rst_n;
  end

  always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per observed pin change
  always @(negedge clk) begin
    if (mon_en) begin
      logic [5:0] cur;
      cur = {hpd_tout, hpd_ready, ready, reset_pin, pwrdn, supply_en};
      for (int i = 0; i < 6; i++) begin
        if (cur[i] != prev_pins[i]) begin
          int code;
          code = i * 2 + int'(cur[i]);
          if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected pin event code", code, -1);
          end else begin
            exp_t e;
            int d;
            e = exp_q.pop_front();
            d = e.anc ? (tick_cnt - anchor) : (tick_cnt - last_stamp);
            chk(code == e.code, e.req, "event code", code, e.code);
            if (e.delta >= 0) chk(d == e.delta, e.req, "tick distance", d, e.delta);
          end
          last_stamp = tick_cnt;
        end
      end
      prev_pins = cur;
    end
  end

  task automatic push(int code, int delta, bit anc, string req);
    exp_t e;
    e.code = code; e.delta = delta; e.anc = anc; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ticks(int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic pulse_resume();
    @(negedge clk) resume_req = 1'b1;
    @(negedge clk) resume_req = 1'b0;
  endtask

  task automatic pulse_suspend();
    @(negedge clk) suspend_req = 1'b1;
    @(negedge clk) suspend_req = 1'b0;
  endtask

  task automatic pulse_activity();
    @(negedge clk) activity = 1'b1;
    @(negedge clk) begin activity = 1'b0; anchor = tick_cnt; end
  endtask

  task automatic pulse_wait(logic lvl_start, logic lvl_after);
    @(negedge clk) begin hpd = lvl_start; hpd_wait = 1'b1; end
    @(negedge clk) begin hpd_wait = 1'b0; hpd = lvl_after; end
  endtask

  task automatic expect_resume(string req);
    push(SUP*2+1, -1, 0, "R1");
    push(PWD*2+0, -1, 0, "R1");
    push(RST*2+0, T_R1, 0, "R1");
    push(RST*2+1, T_GAP, 0, "R2");
    push(RST*2+0, T_R2, 0, "R2");
    push(RDY*2+1, T_SET, 0, "R3");
    push(HPD*2+1, T_EXT, 0, req);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, cur_req, "watchdog expired, cycles", 100000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(supply_en == 1'b0, "R11", "supply_en", supply_en, 0);
    chk(pwrdn == 1'b1, "R11", "pwrdn", pwrdn, 1);
    chk(reset_pin == 1'b1, "R11", "reset", reset_pin, 1);
    chk(ready == 1'b0, "R11", "ready", ready, 0);
    chk(hpd_ready == 1'b0, "R11", "hpd_ready", hpd_ready, 0);
    chk(hpd_tout == 1'b0, "R11", "hpd_tout", hpd_tout, 0);
    rst_n = 1'b1;
    prev_pins = {hpd_tout, hpd_ready, ready, reset_pin, pwrdn, supply_en};
    mon_en = 1'b1;
    repeat (5) @(negedge clk);

    // first resume with HPD already high: double reset, settle, first-HPD delay
    cur_req = "R4";
    hpd = 1'b1;
    expect_resume("R4");
    pulse_resume();
    drain();

    // later wait skips the extra delay
    cur_req = "R5";
    push(HPD*2+0, -1, 0, "R5");
    push(HPD*2+1, T_POLL, 0, "R5");
    pulse_wait(1'b0, 1'b1);
    drain();

    // HPD stays low: timeout at the limit sample
    cur_req = "R6";
    push(HPD*2+0, -1, 0, "R5");
    push(TMO*2+1, T_LIM, 0, "R6");
    pulse_wait(1'b0, 1'b0);
    drain();
    push(HPD*2+1, -1, 0, "R5");
    push(TMO*2+0, 0, 0, "R6");
    pulse_wait(1'b1, 1'b1);
    drain();

    // idle autosuspend, restarted by activity
    cur_req = "R8";
    push(RST*2+1, T_IDLE, 1, "R8");
    push(RDY*2+0, 0, 0, "R7");
    push(HPD*2+0, 0, 0, "R7");
    push(PWD*2+1, 0, 0, "R7");
    push(SUP*2+0, 0, 0, "R7");
    pulse_activity();
    wait_ticks(50);
    pulse_activity();
    drain();

    // activity while off wakes and rearms the first-HPD delay
    cur_req = "R9";
    wait_ticks(3);
    expect_resume("R4");
    pulse_activity();
    drain();
    pulse_resume();
    repeat (20) @(negedge clk);
    chk(ready == 1'b1, "R9", "ready after resume while running", ready, 1);
    chk(exp_q.size() == 0, "R9", "pending events", exp_q.size(), 0);

    // suspend request from running
    cur_req = "R7";
    push(RST*2+1, -1, 0, "R7");
    push(RDY*2+0, 0, 0, "R7");
    push(HPD*2+0, 0, 0, "R7");
    push(PWD*2+1, -1, 0, "R7");
    push(SUP*2+0, -1, 0, "R7");
    pulse_suspend();
    drain();

    // abort during reset gap
    cur_req = "R10";
    push(SUP*2+1, -1, 0, "R1");
    push(PWD*2+0, -1, 0, "R1");
    push(RST*2+0, T_R1, 0, "R1");
    pulse_resume();
    drain();
    wait_ticks(2);
    push(RST*2+1, -1, 0, "R10");
    push(PWD*2+1, -1, 0, "R10");
    push(SUP*2+0, -1, 0, "R10");
    pulse_suspend();
    drain();
    repeat (80) @(negedge clk);
    chk(ready == 1'b0, "R10", "ready after abort in gap", ready, 0);

    // abort during first reset hold (reset already high)
    push(SUP*2+1, -1, 0, "R1");
    push(PWD*2+0, -1, 0, "R1");
    pulse_resume();
    drain();
    push(PWD*2+1, -1, 0, "R10");
    push(SUP*2+0, -1, 0, "R10");
    pulse_suspend();
    drain();
    repeat (80) @(negedge clk);
    chk(ready == 1'b0, "R10", "ready after abort in hold", ready, 0);

    // abort in the supplies-only step
    push(SUP*2+1, -1, 0, "R10");
    push(SUP*2+0, -1, 0, "R10");
    @(negedge clk) resume_req = 1'b1;
    @(negedge clk) begin resume_req = 1'b0; suspend_req = 1'b1; end
    @(negedge clk) suspend_req = 1'b0;
    drain();
    repeat (80) @(negedge clk);
    chk(reset_pin == 1'b1, "R10", "reset after supply-step abort", reset_pin, 1);
    chk(exp_q.size() == 0, "R10", "pending events", exp_q.size(), 0);

    finish_run();
  end

endmodule